// File: doc/BRIEF.md
# Ping-Pong Transpose Buffer

This block sits between the row pass and the column pass of a separable 8x8 two-dimensional transform. It accepts one element per cycle from the row stage and hands the whole block to the column stage in transposed order. Storage is split into two banks. Each bank is a single-port memory that holds one full block.

The banks are used in a fixed overlapping rhythm. The first bank fills. The first bank then drains while the second bank fills, and after that the second bank drains. This repeats for as long as blocks keep arriving. Writes go in row-major order. Reads walk the same bank column by column, so the transposition comes from the address order alone and no data moves between registers.

Each incoming element is saturated to the storage width before it is written. On the output side, a start marker flags the first element of each transposed block and an end marker flags the last.

Top module: `transpose_pingpong`

## Requirements
- R1: While reset is high and in the first cycle after it, rd_valid, rd_sob and rd_eob are 0 and wr_ready is 1.
- R2: An element is stored when wr_valid and wr_ready are both high at a rising edge. Accepted elements are grouped 64 at a time into blocks. Blocks fill bank 0, bank 1, bank 0 and so on, and they leave the read port in the same order they were written.
- R3: Within a block, the k-th written element (k = 0..63) sits at row k/8, column k%8. The j-th output of that block (j = 0..63) is the written element with index (j%8)*8 + j/8.
- R4: Let e be the edge that accepts the 64th element of a block, and let p be the edge after which the previous block's last output appeared. The first output of the block is valid after edge max(e+1, p+1).
- R5: The 64 outputs of one block appear on 64 consecutive cycles, with no gap.
- R6: A bank accepts writes while the other bank is being read. When the input streams without pause, the output of one block follows the previous block with no idle cycle.
- R7: wr_data is a signed 11-bit value. A value above 127 is stored as 127, a value below -128 is stored as -128, and any other value is stored unchanged as a signed 8-bit entry.
- R8: rd_sob is high only together with the first output of a block, and rd_eob is high only together with the 64th output.
- R9: A cycle with wr_valid low stores nothing, whatever is on wr_data, and it does not advance the write position.
- R10: A bank is never written while it is being read. wr_ready is low only while the bank due for writing still holds unread data. When the input streams continuously, wr_ready stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write element present |
| wr_data | input | IN_W (11) | Signed element from the row pass |
| wr_ready | output | 1 | Bank due for writing is free |
| rd_valid | output | 1 | rd_data carries an output element |
| rd_data | output | DATA_W (8) | Signed element in transposed order |
| rd_sob | output | 1 | First element of a transposed block |
| rd_eob | output | 1 | Last element of a transposed block |

## Verification
The bench counts rising edges. For every block it records the edge that accepted its 64th element, and the first output of that block is due after max(that edge + 1, the previous block's last output edge + 1). Each later output of the block is due exactly one edge after the one before it. All outputs are sampled on the falling edge, so every value is compared in the cycle where the requirement places it. Data, markers and timing are all checked against a model that the bench rebuilds from the values it wrote, saturated and transposed by index arithmetic.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
  localparam int NBANK = 2;
  typedef enum logic {BANK_OPEN = 1'b0, BANK_LOADED = 1'b1} bank_state_e;
endpackage

// File: rtl/tpb_sat.sv
module tpb_sat #(
  parameter int IN_W  = 11,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int HI_I = 2 ** (OUT_W - 1) - 1;

  generate
    if (IN_W > OUT_W) begin : g_clamp
      localparam logic signed [IN_W-1:0] HI = IN_W'(HI_I);
      localparam logic signed [IN_W-1:0] LO = IN_W'(-HI_I - 1);
      always_comb begin
        if (din > HI)      dout = HI[OUT_W-1:0];
        else if (din < LO) dout = LO[OUT_W-1:0];
        else               dout = din[OUT_W-1:0];
      end
    end else begin : g_pass
      assign dout = OUT_W'(din);
    end
  endgenerate
endmodule

// File: rtl/tpb_bank.sv
module tpb_bank #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/tpb_seq.sv
module tpb_seq
  import tpb_pkg::*;
#(
  parameter int DIM = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  output logic                      wr_fire,
  output logic                      wr_bank,
  output logic [2*$clog2(DIM)-1:0]  wr_addr,
  output logic                      rd_go,
  output logic                      rd_bank,
  output logic [2*$clog2(DIM)-1:0]  rd_addr,
  output logic                      rd_first,
  output logic                      rd_last
);
  localparam int LW = $clog2(DIM);
  localparam int AW = 2 * LW;
  localparam logic [AW-1:0] LASTIDX = AW'(DIM * DIM - 1);

  bank_state_e    st [NBANK];
  logic [AW-1:0]  wcnt, rcnt;
  logic           wsel, rsel;
  logic [NBANK-1:0] set_v, clr_v;

  assign wr_ready = (st[wsel] == BANK_OPEN);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_go    = (st[rsel] == BANK_LOADED);
  assign wr_bank  = wsel;
  assign rd_bank  = rsel;
  assign wr_addr  = wcnt;
  assign rd_addr  = {rcnt[LW-1:0], rcnt[AW-1:LW]};
  assign rd_first = rd_go && (rcnt == '0);
  assign rd_last  = rd_go && (rcnt == LASTIDX);

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      set_v[b] = wr_fire && (wsel == 1'(b)) && (wcnt == LASTIDX);
      clr_v[b] = rd_go   && (rsel == 1'(b)) && (rcnt == LASTIDX);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0;
      rcnt <= '0;
      wsel <= 1'b0;
      rsel <= 1'b0;
      for (int b = 0; b < NBANK; b++) st[b] <= BANK_OPEN;
    end else begin
      if (wr_fire) begin
        wcnt <= wcnt + 1'b1;
        if (wcnt == LASTIDX) wsel <= ~wsel;
      end
      if (rd_go) begin
        rcnt <= rcnt + 1'b1;
        if (rcnt == LASTIDX) rsel <= ~rsel;
      end
      for (int b = 0; b < NBANK; b++) begin
        if (set_v[b])      st[b] <= BANK_LOADED;
        else if (clr_v[b]) st[b] <= BANK_OPEN;
      end
    end
  end
endmodule

// File: rtl/transpose_pingpong.sv
module transpose_pingpong
  import tpb_pkg::*;
#(
  parameter int IN_W   = 11,
  parameter int DATA_W = 8,
  parameter int DIM    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [IN_W-1:0]   wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sob,
  output logic              rd_eob
);
  localparam int AW = 2 * $clog2(DIM);

  logic              wr_fire, wr_bank, rd_go, rd_bank, rd_first, rd_last;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_sat;
  logic [DATA_W-1:0] bank_q [NBANK];
  logic              rd_bank_q;

  tpb_seq #(.DIM(DIM)) u_seq (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_fire(wr_fire), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .rd_go(rd_go), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_first(rd_first), .rd_last(rd_last)
  );

  tpb_sat #(.IN_W(IN_W), .OUT_W(DATA_W)) u_sat (
    .din($signed(wr_data)), .dout(wr_sat)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic we_b, re_b;
      assign we_b = wr_fire && (wr_bank == 1'(b));
      assign re_b = rd_go   && (rd_bank == 1'(b));
      tpb_bank #(.DW(DATA_W), .AW(AW)) u_mem (
        .clk(clk), .en(we_b || re_b), .we(we_b),
        .addr(we_b ? wr_addr : rd_addr), .wdata(wr_sat), .rdata(bank_q[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_sob    <= 1'b0;
      rd_eob    <= 1'b0;
      rd_bank_q <= 1'b0;
    end else begin
      rd_valid  <= rd_go;
      rd_sob    <= rd_first;
      rd_eob    <= rd_last;
      rd_bank_q <= rd_bank;
    end
  end

  assign rd_data = bank_q[rd_bank_q];
endmodule

// File: rtl/transpose_pingpong_chk.sv
module transpose_pingpong_chk (
  input logic clk,
  input logic rst,
  input logic wr_fire,
  input logic wr_bank,
  input logic rd_go,
  input logic rd_bank,
  input logic wr_ready,
  input logic rd_valid,
  input logic rd_sob,
  input logic rd_eob
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!rd_valid && !rd_sob && !rd_eob && wr_ready));

  assert_block_unbroken_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_eob) |=> (rd_valid && !rd_sob));

  assert_stream_opens_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> rd_sob);

  assert_markers_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_sob || rd_eob) |-> rd_valid);

  assert_after_end_R8: assert property (@(posedge clk) disable iff (rst)
    rd_eob |=> (!rd_valid || rd_sob));

  assert_no_clash_R10: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> !(rd_go && (rd_bank == wr_bank)));
endmodule

bind transpose_pingpong transpose_pingpong_chk u_chk (
  .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_bank(wr_bank),
  .rd_go(rd_go), .rd_bank(rd_bank), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_sob(rd_sob), .rd_eob(rd_eob)
);

// File: tb/tb_transpose_pingpong.sv
module tb_transpose_pingpong;
  localparam int NB = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [10:0] wr_data = '0;
  logic        wr_ready, rd_valid, rd_sob, rd_eob;
  logic [7:0]  rd_data;

  int n_chk = 0, n_bad = 0;
  int ecnt = 0;
  int expv [NB][64];
  int done_edge [NB];
  int oblk = 0, ok = 0, last_edge = -10, stalls = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  transpose_pingpong dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_sob(rd_sob), .rd_eob(rd_eob)
  );

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int pat(input int b, input int i);
    case (b)
      0: return i;
      1: return -(i + 1) * 2;
      2: return ((i * 37) % 2048) - 1024;
      3: return ((i * 73 + 11) % 300) - 150;
      4: return (i % 2 == 0) ? 1023 - i : -1024 + i;
      default: return ((i * 29 + 5) % 256) - 128;
    endcase
  endfunction

  // R2 R9: push 64 elements; gap>0 inserts an idle cycle with junk data
  task automatic push_block(input int b, input int gap);
    for (int i = 0; i < 64; i++) begin
      if (gap > 0 && (i % gap) == gap - 1) begin
        @(negedge clk);
        wr_valid = 1'b0;
        wr_data  = 11'h2AB ^ 11'(i);
      end
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = 11'(pat(b, i));
      expv[b][i] = sat8(pat(b, i));
      while (!wr_ready) begin
        stalls++;
        @(negedge clk);
      end
      if (i == 63) done_edge[b] = ecnt + 1;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = 11'h555;
    repeat (n) @(negedge clk);
  endtask

  // Output monitor: R3 R4 R5 R6 R7 R8
  always @(negedge clk) begin
    if (!rst && !finished && rd_valid) begin
      if (oblk >= NB) begin
        chk(1'b0, "R2 extra output", oblk, NB);
      end else begin
        int e;
        int src;
        src = (ok % 8) * 8 + ok / 8;
        e = expv[oblk][src];
        chk(int'($signed(rd_data)) == e, "R3/R7 data", int'($signed(rd_data)), e);
        chk(rd_sob == (ok == 0), "R8 sob", int'(rd_sob), int'(ok == 0));
        chk(rd_eob == (ok == 63), "R8 eob", int'(rd_eob), int'(ok == 63));
        if (ok == 0) begin
          int due;
          due = (done_edge[oblk] + 1 > last_edge + 1) ? done_edge[oblk] + 1 : last_edge + 1;
          chk(ecnt == due, "R4/R6 first output edge", ecnt, due);
        end else begin
          chk(ecnt == last_edge + 1, "R5 consecutive", ecnt, last_edge + 1);
        end
        last_edge = ecnt;
        if (ok == 63) begin ok = 0; oblk++; end
        else ok++;
      end
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) done_edge[b] = 1 << 30;
    repeat (4) @(negedge clk);
    chk(rd_valid == 1'b0, "R1 rd_valid in reset", int'(rd_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    chk(rd_sob == 1'b0 && rd_eob == 1'b0, "R1 markers", int'(rd_sob | rd_eob), 0);
    chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);

    push_block(0, 0);            // R3 ascending, single block
    idle(80);
    chk(oblk == 1, "R2 one block out", oblk, 1);
    push_block(1, 3);            // R9 bubbles with junk data
    idle(80);
    chk(oblk == 2, "R9 block with bubbles", oblk, 2);
    stalls = 0;
    push_block(2, 0);            // R6 R7 continuous stream, saturation
    push_block(3, 0);
    push_block(4, 0);
    chk(stalls == 0, "R10 no stall on stream", stalls, 0);
    idle(150);
    chk(oblk == 5, "R6 streamed blocks out", oblk, 5);
    push_block(5, 7);
    idle(80);
    chk(oblk == NB, "R2 all blocks in order", oblk, NB);
    chk(rd_valid == 1'b0, "R5 idle after last", int'(rd_valid), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule